// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Sequencer

This block turns a single host request into one complete bus cycle on an external bus where the low address byte and the data byte use the same eight lines. The host gives a 16-bit address, a write byte, a direction bit and a bit that selects the I/O space or the memory space. The request is accepted when the sequencer reports idle. The sequencer first puts the whole address out. The upper byte goes on a dedicated bus and the lower byte goes on the shared lines, together with an address latch pulse so that peripherals can hold the low byte. It then turns the shared lines over to data.

A read releases the shared lines and pulls the read strobe low. A write drives the write byte and pulls the write strobe low. The external ready input passes through a synchroniser chain before the sequencer uses it. While the synchronised ready is low, the sequencer inserts wait states. At the end of the cycle the strobe rises, read data is captured, and a one-clock done pulse is given with the data.

Top module: `mux_bus_seq`

## Requirements
- R1: A request (`req_valid` high) is accepted only in a cycle where `idle` is high. A request presented while a bus cycle is in progress is ignored and starts no extra address phase.
- R2: The first state after acceptance lasts one clock. In it `ale` is 1, `addr_hi` carries address bits 15..8, `ad_out` carries bits 7..0 with `ad_oe` = 1, and both `rd_n` and `wr_n` are 1.
- R3: `io_m` is 1 for an I/O cycle (`req_io` = 1) and 0 for a memory cycle, from the address state through the last strobe state.
- R4: In a read (`req_write` = 0), `rd_n` is 0 from the clock after the address state until the end of the cycle, `wr_n` stays 1, and `ad_oe` is 0 the whole time.
- R5: In a write (`req_write` = 1), `wr_n` is 0 over the same span, `rd_n` stays 1, and `ad_oe` = 1 with `ad_out` equal to the write byte.
- R6: `rd_n` and `wr_n` are never both 0. Both are 1 whenever no cycle is running.
- R7: `bus_ready` is used only after SYNC_STAGES (default 2) flip-flops. If it is held high, the strobe is low for exactly 2 clocks. If it is low before the strobe falls and rises K clocks after the strobe is first seen low, the strobe is low for K+SYNC_STAGES+2 clocks.
- R8: In the clock after the strobe rises, `done` is 1 for exactly one clock. For a read, `rdata` then holds the byte that was on `ad_in` in the last strobe-low clock.
- R9: While the synchronous active-high `rst` is sampled high, the next clock shows `idle` = 1, `rd_n` = `wr_n` = 1, `ad_oe` = 0, `ale` = 0 and `done` = 0, even in the middle of a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Host request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory space |
| req_addr | input | 16 | Cycle address |
| req_wdata | input | 8 | Write byte |
| idle | output | 1 | Sequencer can accept a request |
| done | output | 1 | One-clock end-of-cycle pulse |
| rdata | output | 8 | Captured read byte |
| addr_hi | output | 8 | Dedicated upper address byte |
| ad_out | output | 8 | Shared lines, outgoing value |
| ad_oe | output | 1 | Shared lines output enable |
| ad_in | input | 8 | Shared lines, incoming value |
| ale | output | 1 | Address latch pulse |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| io_m | output | 1 | I/O (1) or memory (0) select |
| bus_ready | input | 1 | Asynchronous ready from the addressed device |

## Verification
The address phase appears one clock after the accepting edge. The strobe falls on the next clock. After that it stays low for 2 clocks, or for K+2+2 clocks when ready rises K clocks after the strobe is first seen low, and done follows in the clock after the strobe rises. A scoreboard checks the queued item against the bus on every falling edge. It counts strobe-low clocks from the address pulse to done, so every wait-state result is compared with the count that the synchroniser depth predicts. The tests cover back-to-back memory and I/O cycles, several ready delays, a request held during a busy cycle and a reset applied in the middle of a wait.

// File: rtl/mux_bus_seq.sv
module mux_bus_seq #(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       req_valid,
  input  logic                       req_write,
  input  logic                       req_io,
  input  logic [ADDR_W-1:0]          req_addr,
  input  logic [DATA_W-1:0]          req_wdata,
  output logic                       idle,
  output logic                       done,
  output logic [DATA_W-1:0]          rdata,
  output logic [ADDR_W-DATA_W-1:0]   addr_hi,
  output logic [DATA_W-1:0]          ad_out,
  output logic                       ad_oe,
  input  logic [DATA_W-1:0]          ad_in,
  output logic                       ale,
  output logic                       rd_n,
  output logic                       wr_n,
  output logic                       io_m,
  input  logic                       bus_ready
);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_STRB, S_WAIT, S_LAST} state_t;

  state_t                 state;
  logic [ADDR_W-1:0]      addr_q;
  logic [DATA_W-1:0]      wdata_q;
  logic                   wr_q;
  logic                   io_q;
  logic [SYNC_STAGES-1:0] rdy_pipe;
  logic                   rdy_sync;
  logic                   strobe;

  assign rdy_sync = rdy_pipe[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      rdy_pipe <= '0;
    end else begin
      rdy_pipe[0] <= bus_ready;
      for (int i = 1; i < SYNC_STAGES; i++) rdy_pipe[i] <= rdy_pipe[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      done    <= 1'b0;
      rdata   <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      wr_q    <= 1'b0;
      io_q    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        S_IDLE: if (req_valid) begin
          state   <= S_ADDR;
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          wr_q    <= req_write;
          io_q    <= req_io;
        end
        S_ADDR: state <= S_STRB;
        S_STRB: state <= rdy_sync ? S_LAST : S_WAIT;
        S_WAIT: if (rdy_sync) state <= S_LAST;
        S_LAST: begin
          state <= S_IDLE;
          done  <= 1'b1;
          if (!wr_q) rdata <= ad_in;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign strobe  = (state == S_STRB) || (state == S_WAIT) || (state == S_LAST);
  assign idle    = (state == S_IDLE);
  assign ale     = (state == S_ADDR);
  assign rd_n    = !(strobe && !wr_q);
  assign wr_n    = !(strobe && wr_q);
  assign io_m    = !idle && io_q;
  assign addr_hi = addr_q[ADDR_W-1:DATA_W];
  assign ad_oe   = ale || (strobe && wr_q);
  assign ad_out  = ale ? addr_q[DATA_W-1:0] : wdata_q;

  a_r6_strobes_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(!rd_n && !wr_n));
  a_r2_ale_strobes_high: assert property (@(posedge clk) disable iff (rst)
    ale |-> (rd_n && wr_n && ad_oe));
  a_r2_ale_then_strobe: assert property (@(posedge clk) disable iff (rst)
    ale |=> (!rd_n || !wr_n));
  a_r4_read_floats: assert property (@(posedge clk) disable iff (rst)
    !rd_n |-> !ad_oe);
  a_r5_write_drives: assert property (@(posedge clk) disable iff (rst)
    !wr_n |-> ad_oe);
  a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r1_addr_held_busy: assert property (@(posedge clk) disable iff (rst)
    (!idle && !ale) |-> $stable(addr_hi));
  a_r9_reset_quiet: assert property (@(posedge clk)
    rst |=> (rd_n && wr_n && !ad_oe && idle));

endmodule

// File: tb/mux_bus_seq_bench.sv
module mux_bus_seq_bench;
  localparam int S = 2;

  typedef struct packed {
    logic        wr;
    logic        io;
    logic [15:0] addr;
    logic [7:0]  data;
    int          strobes;
  } item_t;

  logic clk = 0, rst = 1;
  logic req_valid = 0, req_write = 0, req_io = 0;
  logic [15:0] req_addr = 0;
  logic [7:0]  req_wdata = 0;
  logic idle, done, ad_oe, ale, rd_n, wr_n, io_m;
  logic [7:0] rdata, addr_hi, ad_out, ad_in;
  logic bus_ready = 1;
  logic [15:0] mem_addr = 0;

  int checks = 0, fails = 0, pushes = 0, ales = 0, cyc = 0;
  item_t q[$];
  item_t cur;
  bit in_txn = 0, prev_done = 0;
  int cnt = 0;

  always #2.5 clk = ~clk;

  mux_bus_seq #(.SYNC_STAGES(S)) u_mux_bus_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_io(req_io), .req_addr(req_addr), .req_wdata(req_wdata),
    .idle(idle), .done(done), .rdata(rdata), .addr_hi(addr_hi),
    .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in), .ale(ale),
    .rd_n(rd_n), .wr_n(wr_n), .io_m(io_m), .bus_ready(bus_ready));

  function automatic logic [7:0] model(input logic [15:0] a, input logic io);
    return a[7:0] ^ a[15:8] ^ (io ? 8'hC3 : 8'h3C);
  endfunction

  assign ad_in = model(mem_addr, io_m);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst) begin
      in_txn = 0;
      prev_done = 0;
    end else begin
      chk(!(!rd_n && !wr_n), "R6 strobes both low", {rd_n, wr_n}, 3);
      if (ale) begin
        ales++;
        if (q.size() == 0) chk(0, "R1 unexpected address phase", addr_hi, 0);
        else begin
          cur = q.pop_front();
          mem_addr = {addr_hi, ad_out};
          chk(addr_hi == cur.addr[15:8], "R2 addr_hi", addr_hi, cur.addr[15:8]);
          chk(ad_out == cur.addr[7:0] && ad_oe, "R2 low addr on shared", ad_out, cur.addr[7:0]);
          chk(rd_n && wr_n, "R2 strobes high in T1", {rd_n, wr_n}, 3);
          chk(io_m == cur.io, "R3 io_m in T1", io_m, cur.io);
          in_txn = 1;
          cnt = 0;
        end
      end
      if (in_txn && (!rd_n || !wr_n)) begin
        cnt++;
        chk(io_m == cur.io, "R3 io_m in strobe", io_m, cur.io);
        if (cur.wr) begin
          chk(!wr_n && rd_n, "R5 write strobe", {rd_n, wr_n}, 2);
          chk(ad_oe && ad_out == cur.data, "R5 write data", ad_out, cur.data);
        end else begin
          chk(!rd_n && wr_n, "R4 read strobe", {rd_n, wr_n}, 1);
          chk(!ad_oe, "R4 shared lines released", ad_oe, 0);
        end
      end
      if (done) begin
        chk(in_txn, "R8 done without cycle", 1, 0);
        chk(!prev_done, "R8 done longer than one clock", 1, 0);
        if (in_txn) begin
          chk(cnt == cur.strobes, "R7 strobe length", cnt, cur.strobes);
          if (!cur.wr) chk(rdata == model(cur.addr, cur.io), "R8 read data", rdata, model(cur.addr, cur.io));
        end
        in_txn = 0;
      end
      prev_done = done;
    end
  end

  task automatic run(input bit wr, input bit io, input logic [15:0] a,
                     input logic [7:0] d, input int k, input bit junk);
    item_t it;
    @(negedge clk);
    while (!idle) @(negedge clk);
    if (k >= 0) begin
      bus_ready = 0;
      repeat (S + 2) @(negedge clk);
    end else bus_ready = 1;
    it.wr = wr; it.io = io; it.addr = a; it.data = d;
    it.strobes = (k < 0) ? 2 : k + S + 2;
    q.push_back(it);
    pushes++;
    chk(idle, "R1 idle before request", idle, 1);
    req_valid = 1; req_write = wr; req_io = io; req_addr = a; req_wdata = d;
    @(negedge clk);
    if (junk) begin
      req_write = !wr; req_io = !io; req_addr = ~a; req_wdata = ~d;
      chk(!idle, "R1 busy after accept", idle, 0);
    end else req_valid = 0;
    @(negedge clk);
    if (k >= 0) begin
      repeat (k) @(negedge clk);
      bus_ready = 1;
    end
    @(negedge clk);
    req_valid = 0;
    while (!done) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(ales == pushes, "R1 address phases per request", ales, pushes);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(idle && rd_n && wr_n && !ad_oe && !ale && !done, "R9 reset state",
        {idle, rd_n, wr_n, ad_oe, ale, done}, 6'b111000);
    rst = 0;
    run(0, 0, 16'h1234, 8'h00, -1, 0);
    run(1, 0, 16'hFFFF, 8'hA5, -1, 0);
    run(0, 1, 16'h0000, 8'h00, -1, 0);
    run(1, 1, 16'h80F0, 8'h5A, -1, 0);
    run(0, 0, 16'h4321, 8'h00, 0, 0);
    run(1, 0, 16'h0F0F, 8'h3C, 3, 0);
    run(0, 1, 16'hBEEF, 8'h00, 5, 0);
    run(0, 0, 16'h7E81, 8'h00, -1, 1);
    run(1, 1, 16'h2002, 8'hFE, -1, 1);
    // R9: reset in the middle of a wait
    @(negedge clk);
    bus_ready = 0;
    repeat (S + 2) @(negedge clk);
    req_valid = 1; req_write = 0; req_io = 0; req_addr = 16'h5555;
    q.push_back('{wr: 0, io: 0, addr: 16'h5555, data: 0, strobes: 0});
    pushes++;
    @(negedge clk);
    req_valid = 0;
    repeat (4) @(negedge clk);
    rst = 1;
    @(negedge clk);
    chk(idle && rd_n && wr_n && !ad_oe && !ale && !done, "R9 reset mid-cycle",
        {idle, rd_n, wr_n, ad_oe, ale, done}, 6'b111000);
    @(negedge clk);
    rst = 0;
    bus_ready = 1;
    run(0, 1, 16'hC001, 8'h00, 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 50000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule